// File: doc/BRIEF.md
# Legacy Fast A20 and CPU Reset Controller

This block is the legacy PC system-control port. It has two jobs. The first is an alternate way to open the A20 address gate. The second is a quick way to reset the CPU without waiting on the keyboard controller. Software reaches it through one byte-wide register, with a write strobe and a combinational read path.

A register bit is ORed with the A20 request from a keyboard-controller emulation to drive the combined A20 gate output. Setting the reset-request bit starts a fixed delay. When the delay ends, an active-low reset pulse of at least a minimum width is produced. Both intervals are computed from a clock-frequency parameter. A pulse only fires on a 0-then-1 sequence of the request bit, so software must clear the bit before it can ask for another pulse.

An enable input gates the whole port. While the port is disabled, register writes are ignored, and the A20 output follows the keyboard-controller request alone.

Top module: `fast_a20_reset_ctrl`

## Requirements
- R1: `rd_data` returns the A20 bit in bit position 1 and the reset-request bit in bit position 0. Positions 7:2 always read 0, and writes to them have no effect.
- R2: While `rst_n` is low and after it is released, both register bits are 0, `cpu_rst_n` is 1 and `gate_a20` equals `kbc_a20`.
- R3: Whenever the A20 register bit is 1, `gate_a20` is 1, whatever the level of `kbc_a20`.
- R4: `gate_a20` is 0 only when both the A20 register bit and `kbc_a20` are 0. In all other cases it is 1.
- R5: A write strobe while `port_en` is 0 changes neither register bit and starts no reset pulse.
- R6: An accepted write with bit 0 set, at clock edge N, drives `cpu_rst_n` low from edge N+D to edge N+D+P. Here D is ceil(DELAY_NS·CLK_HZ/1e9) and P is ceil(PULSE_NS·CLK_HZ/1e9), each at least 1 cycle.
- R7: After a pulse has been started, no further pulse starts until an accepted write with bit 0 clear is followed by an accepted write with bit 0 set.
- R8: A write with bit 0 set while a delay or pulse is in progress does not restart or extend the pulse. It also consumes the rearm, so a later write of 1 starts nothing until the bit has been cleared again.
- R9: Bit 0 reads back the last value accepted, including during a delay or pulse.
- R10: `cpu_rst_n` is 1 whenever no pulse is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rst_n | input | 1 | Active-low system I/O reset |
| port_en | input | 1 | Port enable; gates writes and pulse starts |
| wr_stb | input | 1 | One-cycle register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| kbc_a20 | input | 1 | A20 request from the keyboard-controller emulation |
| gate_a20 | output | 1 | Combined A20 gate |
| cpu_rst_n | output | 1 | Active-low CPU reset pulse |

## Verification
The bench builds the block with CLK_HZ = 3,333,333 and keeps the default 14 µs delay and 6 µs pulse. The raw products then give 46.67 and 19.99 cycles, so both intervals must round up, to 47 and 20 cycles. Because the windows are this short, a full delay plus pulse fits many times into a short run. Random writes can therefore land before, inside and after the delay and pulse windows, and this exercises the busy and rearm rules many times.

// File: rtl/fa20_pkg.sv
package fa20_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned BIT_RST = 0;
  localparam int unsigned BIT_A20 = 1;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_PULSE = 2'd2
  } phase_t;

  // Convert a time in ns to whole clock cycles, rounding up; never below 1.
  function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = ns * hz;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return int'(cyc[31:0]);
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int unsigned bits_for(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fa20_regs.sv
module fa20_regs
  import fa20_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  input  logic             busy,
  output logic             alt_a20,
  output logic             rst_req,
  output logic             fire,
  output logic [REG_W-1:0] rd_data
);

  logic wr_ok;
  logic armed;
  logic unused_resv;

  assign wr_ok = wr_stb & port_en;

  // A pulse starts only on an accepted 1 while armed and the generator is idle.
  assign fire = wr_ok & wr_data[BIT_RST] & armed & ~busy;

  assign unused_resv = ^wr_data[REG_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_a20 <= 1'b0;
      rst_req <= 1'b0;
      armed   <= 1'b1;
    end else if (wr_ok) begin
      alt_a20 <= wr_data[BIT_A20];
      rst_req <= wr_data[BIT_RST];
      // Writing 0 rearms; any write of 1 consumes the arm.
      armed   <= ~wr_data[BIT_RST];
    end
  end

  generate
    for (genvar b = 0; b < REG_W; b++) begin : g_rd
      if (b == BIT_A20) begin : g_a20
        assign rd_data[b] = alt_a20;
      end else if (b == BIT_RST) begin : g_rst
        assign rd_data[b] = rst_req;
      end else begin : g_resv
        assign rd_data[b] = 1'b0;
      end
    end
  endgenerate

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en) |=> ($stable(alt_a20) && $stable(rst_req))); // R5

  AST_FIRE_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (rst_req == 1'b0)); // R7

  AST_FIRE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> port_en); // R5

endmodule

// File: rtl/fa20_gate.sv
module fa20_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic alt_a20,
  input  logic kbc_a20,
  output logic gate_a20
);

  assign gate_a20 = alt_a20 | kbc_a20;

  AST_ALT_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    alt_a20 |-> gate_a20); // R3

  AST_LOW_ONLY_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_a20) |-> (!alt_a20 && !kbc_a20)); // R4

endmodule

// File: rtl/fa20_pulse.sv
module fa20_pulse
  import fa20_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 700,
  parameter int unsigned PULSE_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy,
  output logic delay_done,
  output logic pulse_done,
  output logic rst_out_n
);

  localparam int unsigned CW    = bits_for(max2(DELAY_CYC, PULSE_CYC));
  localparam logic [CW-1:0] D_LOAD = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] P_LOAD = CW'(PULSE_CYC - 1);
  localparam int unsigned CHK_W = bits_for(DELAY_CYC + PULSE_CYC + 2);

  phase_t        state, state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          low_q;

  assign delay_done = (state == PH_DELAY) && (cnt == '0);
  assign pulse_done = (state == PH_PULSE) && (cnt == '0);
  assign busy       = (state != PH_IDLE);

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    unique case (state)
      PH_IDLE: begin
        if (fire) begin
          state_nxt = PH_DELAY;
          cnt_nxt   = D_LOAD;
        end
      end
      PH_DELAY: begin
        if (delay_done) begin
          state_nxt = PH_PULSE;
          cnt_nxt   = P_LOAD;
        end else begin
          cnt_nxt = cnt - 1'b1;
        end
      end
      PH_PULSE: begin
        if (pulse_done) begin
          state_nxt = PH_IDLE;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt - 1'b1;
        end
      end
      default: begin
        state_nxt = PH_IDLE;
        cnt_nxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      cnt   <= '0;
      low_q <= 1'b0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
      low_q <= (state_nxt == PH_PULSE);
    end
  end

  assign rst_out_n = ~low_q;

  // Cycle counter since the last start, kept only for the timing checks.
  logic [CHK_W-1:0] since_fire;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_fire <= '0;
    else if (fire)             since_fire <= CHK_W'(1);
    else if (since_fire != '1) since_fire <= since_fire + 1'b1;
  end

  AST_DELAY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> (since_fire == CHK_W'(DELAY_CYC + 1))); // R6

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> (since_fire == CHK_W'(DELAY_CYC + PULSE_CYC + 1))); // R6

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy); // R8

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE) |-> rst_out_n); // R10

endmodule

// File: rtl/fast_a20_reset_ctrl.sv
module fast_a20_reset_ctrl
  import fa20_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned DELAY_NS = 14_000,
  parameter int unsigned PULSE_NS = 6_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             kbc_a20,
  output logic             gate_a20,
  output logic             cpu_rst_n
);

  localparam int unsigned DELAY_CYC = ns_to_cycles(64'(CLK_HZ), 64'(DELAY_NS));
  localparam int unsigned PULSE_CYC = ns_to_cycles(64'(CLK_HZ), 64'(PULSE_NS));

  // Named internal events for the assertions.
  logic alt_a20;
  logic rst_req;
  logic fire;
  logic busy;
  logic delay_done;
  logic pulse_done;

  fa20_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_en (port_en),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .busy    (busy),
    .alt_a20 (alt_a20),
    .rst_req (rst_req),
    .fire    (fire),
    .rd_data (rd_data)
  );

  fa20_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .alt_a20  (alt_a20),
    .kbc_a20  (kbc_a20),
    .gate_a20 (gate_a20)
  );

  fa20_pulse #(
    .DELAY_CYC (DELAY_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .busy       (busy),
    .delay_done (delay_done),
    .pulse_done (pulse_done),
    .rst_out_n  (cpu_rst_n)
  );

  AST_PULSE_NEEDS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_n) |-> $past(delay_done)); // R6

  AST_PULSE_ENDS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> $past(pulse_done)); // R10

  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:2] == '0); // R1

endmodule

// File: tb/sim_fast_a20_reset_ctrl.sv
module sim_fast_a20_reset_ctrl;

  localparam int unsigned HZ   = 3_333_333;
  localparam int unsigned DNS  = 14_000;
  localparam int unsigned PNS  = 6_000;

  // Smallest cycle count whose duration covers ns.
  function automatic int cyc_cover(longint unsigned hz, longint unsigned ns);
    longint unsigned c = 0;
    while (c * 64'd1_000_000_000 < ns * hz) c++;
    return (c == 0) ? 1 : int'(c);
  endfunction

  localparam int D = cyc_cover(HZ, DNS);
  localparam int P = cyc_cover(HZ, PNS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic kbc_a20 = 1'b0;
  logic gate_a20;
  logic cpu_rst_n;

  always #10 clk = ~clk;  // 50 MHz

  fast_a20_reset_ctrl #(.CLK_HZ(HZ), .DELAY_NS(DNS), .PULSE_NS(PNS)) u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .kbc_a20(kbc_a20),
    .gate_a20(gate_a20), .cpu_rst_n(cpu_rst_n)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // Model state.
  logic alt_m = 0, bit_m = 0, armed_m = 1, fire_v = 0;
  int fire_c = 0;
  int exp_fires = 0;
  int falls = 0;
  logic prev_rn = 1'b1;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic busy_at(int n);
    return fire_v && (n > fire_c) && (n <= fire_c + D + P);
  endfunction

  function automatic logic exp_low(int n);
    return fire_v && (n >= fire_c + D) && (n < fire_c + D + P);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Continuous comparison a little after each edge.
  always @(posedge clk) begin
    #5;
    if (!rst_n) begin
      chk("R2 rd_data", rd_data, 0);
      chk("R2 cpu_rst_n", cpu_rst_n, 1);
      chk("R2 gate_a20", gate_a20, kbc_a20);
    end else begin
      chk("R1 R9 rd_data", rd_data, {6'b0, alt_m, bit_m});
      chk("R3 R4 gate_a20", gate_a20, alt_m | kbc_a20);
      chk("R6 R10 cpu_rst_n", cpu_rst_n, !exp_low(cyc));
    end
    if (prev_rn && !cpu_rst_n) falls++;
    prev_rn = cpu_rst_n;
  end

  task automatic wr(logic en, logic [7:0] d);
    int n;
    @(negedge clk);
    port_en = en; wr_stb = 1'b1; wr_data = d;
    @(posedge clk); #1;
    n = cyc;
    if (en) begin
      alt_m = d[1];
      bit_m = d[0];
      if (d[0]) begin
        if (armed_m && !busy_at(n)) begin
          fire_v = 1; fire_c = n; exp_fires++;
        end
        armed_m = 0;
      end else begin
        armed_m = 1;
      end
    end
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R2: reset state, both kbc levels
    idle(2); kbc_a20 = 1'b1; idle(2); kbc_a20 = 1'b0; idle(2);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    chk("R2 rd after release", rd_data, 0);

    // R4: kbc alone drives gate
    kbc_a20 = 1'b1; idle(2); chk("R4 kbc high", gate_a20, 1);
    kbc_a20 = 1'b0; idle(2); chk("R4 both low", gate_a20, 0);

    // R3: alt bit forces gate high
    wr(1'b1, 8'h02); idle(1);
    chk("R3 alt forces high", gate_a20, 1);

    // R1: reserved bits ignored
    wr(1'b1, 8'hFC); idle(1);
    chk("R1 reserved ignored", rd_data, 8'h00);

    // R5: disabled write changes nothing, starts nothing
    wr(1'b0, 8'h03); idle(1);
    chk("R5 disabled write", rd_data, 8'h00);
    idle(D + P + 4);
    chk("R5 no pulse", falls, 0);

    // R6 R8: start, then writes during delay and pulse
    wr(1'b1, 8'h01);
    idle(5);
    wr(1'b1, 8'h01);       // busy: no restart
    wr(1'b1, 8'h00);       // rearm during delay
    idle(D - 6);
    wr(1'b1, 8'h01);       // inside pulse: ignored, consumes arm
    chk("R9 readback in pulse", rd_data, 8'h01);
    idle(D + P + 4);
    chk("R8 one pulse", falls, 1);

    // R7: 1 without clearing does nothing; 0 then 1 fires
    wr(1'b1, 8'h01); idle(D + P + 4);
    chk("R7 no refire", falls, 1);
    wr(1'b1, 8'h00); wr(1'b1, 8'h03); idle(D + P + 4);
    chk("R7 rearmed fires", falls, 2);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      kbc_a20 = 1'($urandom_range(0, 1));
      if (op < 5) wr(($urandom_range(0, 9) < 8), 8'($urandom_range(0, 255)));
      else idle(int'($urandom_range(1, 30)));
    end
    idle(D + P + 4);
    chk("R7 R8 total pulses", falls, exp_fires);
    finish_run();
  end

endmodule